// File: doc/BRIEF.md
# Privilege-Gated Interrupt Selector

This block sits beside a hart that runs in machine or supervisor mode. It chooses which of its N interrupt sources, if any, is offered to the core. Each source has the following attributes:

- a raw request line and an enable;
- a target mode (machine or supervisor);
- a trigger kind (level or edge);
- a vectored flag;
- an 8-bit level.

The selector keeps one pending bit per source. A level source's pending bit follows its line. An edge source's pending bit is set by a rising edge and held until it is cleared.

Whether a source may be taken depends on four things: the hart's current privilege, the global enable of the source's mode, the threshold of that mode, and the level already being serviced in that mode. Among the sources that pass these gates, machine-mode sources come first, then higher level, then higher index.

The winner is offered through a small handshake. While it is offered, `take_req` is high and the winner's index, level, mode and vectored flag are shown beside it. When the core pulses `take_ack` on a vectored edge source, that source's pending bit is cleared automatically.

The handshake is a three-state machine:

- ST_IDLE (nothing offered) moves to ST_OFFER when an eligible winner exists.
- ST_OFFER moves to ST_HOLD on an acknowledge. It falls back to ST_IDLE if no winner remains.
- ST_HOLD suppresses the request for one cycle after an acknowledge. It then moves to ST_OFFER if a winner exists, otherwise to ST_IDLE.

Top module: `irq_arb_top`

## Requirements
- R1: A source whose enable is 0 is never offered, whatever its line does.
- R2: With the hart in machine mode (`priv_s`=0), a machine-mode source (`irq_smode` bit 0) is offered only while `mie` is 1.
- R3: A source is offered only if its level is strictly greater than the threshold of its own mode (`m_thresh` or `s_thresh`).
- R4: With the hart in supervisor mode (`priv_s`=1), an enabled pending machine-mode source is offered even when `mie` is 0.
- R5: A supervisor-mode source (`irq_smode` bit 1) is never offered while `priv_s`=0, even with `sie`=1.
- R6: With `priv_s`=1, a supervisor-mode source is offered only while `sie` is 1.
- R7: When machine-mode and supervisor-mode sources are both eligible, a machine-mode one is offered, even if its level is lower.
- R8: Within one mode, the higher level is offered. When the levels are equal, the higher index is offered.
- R9: A source whose level is not above the active level of its mode (`m_active` or `s_active`) is not offered. It is offered once that active level drops below it.
- R10: Pending state for an edge source (`irq_edge` bit 1) is set by a rising line. An acknowledge clears it when the source is vectored (`irq_vec` bit 1). A non-vectored edge source stays pending after an acknowledge until its `irq_sw_clr` bit is pulsed.
- R11: A level source whose line is still high is offered again after an acknowledge.
- R12: Timing:
  - `take_req` is 0 after reset.
  - It rises one clock after a configuration input makes a pending source eligible.
  - It rises two clocks after a level line rises.
  - It is 0 in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_line | input | N_IRQ | Raw request line per source |
| irq_sw_clr | input | N_IRQ | Clear pulse for edge pending bits |
| irq_en | input | N_IRQ | Per-source enable |
| irq_smode | input | N_IRQ | 1 = supervisor target, 0 = machine target |
| irq_edge | input | N_IRQ | 1 = edge trigger, 0 = level trigger |
| irq_vec | input | N_IRQ | 1 = vectored source |
| irq_lvl | input | N_IRQ*LVL_W | Level per source, source i at bits i*LVL_W |
| priv_s | input | 1 | Hart privilege: 1 = supervisor, 0 = machine |
| mie | input | 1 | Machine global enable |
| sie | input | 1 | Supervisor global enable |
| m_thresh | input | LVL_W | Machine threshold |
| s_thresh | input | LVL_W | Supervisor threshold |
| m_active | input | LVL_W | Level being serviced in machine mode |
| s_active | input | LVL_W | Level being serviced in supervisor mode |
| take_ack | input | 1 | Core accepts the offered source |
| take_req | output | 1 | A source is offered |
| take_id | output | ID_W | Index of the offered source |
| take_lvl | output | LVL_W | Level of the offered source |
| take_smode | output | 1 | Mode of the offered source |
| take_vec | output | 1 | Vectored flag of the offered source |

## Verification
Two acknowledge paths are hard to reach from the ports. The first is the one that must clear an edge source's pending bit. The second is the one that must leave a non-vectored edge source pending. Both need a single-cycle line pulse, a wait until the offer is visible, and an acknowledge aimed at exactly that offer.

The bench drives these sequences at falling edges, so the acknowledge meets the ST_OFFER state. It then observes `take_req` across the ST_HOLD cycle and the cycle after it, which separates an automatic clear from a re-offer.

Preemption against the active level is reached by holding a level source high and moving `m_active` across the source's level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HOLD  = 2'd2
    } arb_state_t;

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic is_edge,
    input  logic sw_clr,
    input  logic ack_clr,
    output logic pend
);

    logic line_q;
    logic pend_q;
    logic rise;

    assign rise = line & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            line_q <= line;
            if (is_edge) begin
                if (rise)
                    pend_q <= 1'b1;
                else if (sw_clr || ack_clr)
                    pend_q <= 1'b0;
            end else begin
                pend_q <= line;
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int N_IRQ = 16,
    parameter int LVL_W = 8
) (
    input  logic [N_IRQ-1:0]       pend,
    input  logic [N_IRQ-1:0]       en,
    input  logic [N_IRQ-1:0]       smode,
    input  logic [N_IRQ*LVL_W-1:0] lvl,
    input  logic                   priv_s,
    input  logic                   mie,
    input  logic                   sie,
    input  logic [LVL_W-1:0]       m_thresh,
    input  logic [LVL_W-1:0]       s_thresh,
    input  logic [LVL_W-1:0]       m_active,
    input  logic [LVL_W-1:0]       s_active,
    output logic [N_IRQ-1:0]       elig
);

    logic m_open;
    logic s_open;

    // machine sources always open from supervisor; supervisor sources never from machine
    assign m_open = priv_s | mie;
    assign s_open = priv_s & sie;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        logic [LVL_W-1:0] l;
        logic [LVL_W-1:0] thr;
        logic [LVL_W-1:0] act;
        logic             mode_ok;
        assign l       = lvl[i*LVL_W +: LVL_W];
        assign thr     = smode[i] ? s_thresh : m_thresh;
        assign act     = smode[i] ? s_active : m_active;
        assign mode_ok = smode[i] ? s_open : m_open;
        assign elig[i] = pend[i] & en[i] & mode_ok & (l > thr) & (l > act);
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_IRQ = 16,
    parameter int LVL_W = 8,
    localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0]       elig,
    input  logic [N_IRQ-1:0]       smode,
    input  logic [N_IRQ*LVL_W-1:0] lvl,
    output logic                   win_valid,
    output logic [ID_W-1:0]        win_id,
    output logic [LVL_W-1:0]       win_lvl,
    output logic                   win_smode
);

    // key: machine mode above supervisor, then level; later index wins ties
    logic [LVL_W:0] best_key;

    always_comb begin
        best_key  = '0;
        win_valid = 1'b0;
        win_id    = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            logic [LVL_W:0] k;
            k = {~smode[i], lvl[i*LVL_W +: LVL_W]};
            if (elig[i] && (!win_valid || k >= best_key)) begin
                win_valid = 1'b1;
                best_key  = k;
                win_id    = ID_W'(i);
            end
        end
        win_lvl   = best_key[LVL_W-1:0];
        win_smode = ~best_key[LVL_W];
    end

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ = 16,
    parameter int LVL_W = 8,
    localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IRQ-1:0]       irq_line,
    input  logic [N_IRQ-1:0]       irq_sw_clr,
    input  logic [N_IRQ-1:0]       irq_en,
    input  logic [N_IRQ-1:0]       irq_smode,
    input  logic [N_IRQ-1:0]       irq_edge,
    input  logic [N_IRQ-1:0]       irq_vec,
    input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
    input  logic                   priv_s,
    input  logic                   mie,
    input  logic                   sie,
    input  logic [LVL_W-1:0]       m_thresh,
    input  logic [LVL_W-1:0]       s_thresh,
    input  logic [LVL_W-1:0]       m_active,
    input  logic [LVL_W-1:0]       s_active,
    input  logic                   take_ack,
    output logic                   take_req,
    output logic [ID_W-1:0]        take_id,
    output logic [LVL_W-1:0]       take_lvl,
    output logic                   take_smode,
    output logic                   take_vec
);

    arb_state_t       state_q, state_d;
    logic [N_IRQ-1:0] pend;
    logic [N_IRQ-1:0] elig;
    logic [N_IRQ-1:0] ack_clr;
    logic             win_valid;
    logic [ID_W-1:0]  win_id;
    logic [LVL_W-1:0] win_lvl;
    logic             win_smode;
    logic             acked;

    assign acked = take_ack && (state_q == ST_OFFER);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_cell
        // auto-clear only for the acknowledged vectored edge source
        assign ack_clr[i] = acked && take_vec && irq_edge[i] && (take_id == ID_W'(i));

        irq_pend_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .line    (irq_line[i]),
            .is_edge (irq_edge[i]),
            .sw_clr  (irq_sw_clr[i]),
            .ack_clr (ack_clr[i]),
            .pend    (pend[i])
        );
    end

    irq_gate #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_gate (
        .pend     (pend),
        .en       (irq_en),
        .smode    (irq_smode),
        .lvl      (irq_lvl),
        .priv_s   (priv_s),
        .mie      (mie),
        .sie      (sie),
        .m_thresh (m_thresh),
        .s_thresh (s_thresh),
        .m_active (m_active),
        .s_active (s_active),
        .elig     (elig)
    );

    irq_pick #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_pick (
        .elig      (elig),
        .smode     (irq_smode),
        .lvl       (irq_lvl),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_lvl   (win_lvl),
        .win_smode (win_smode)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = win_valid ? ST_OFFER : ST_IDLE;
            ST_OFFER: begin
                if (take_ack)
                    state_d = ST_HOLD;
                else if (!win_valid)
                    state_d = ST_IDLE;
                else
                    state_d = ST_OFFER;
            end
            ST_HOLD:  state_d = win_valid ? ST_OFFER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_id    <= '0;
            take_lvl   <= '0;
            take_smode <= 1'b0;
            take_vec   <= 1'b0;
        end else if (state_d == ST_OFFER) begin
            take_id    <= win_id;
            take_lvl   <= win_lvl;
            take_smode <= win_smode;
            take_vec   <= irq_vec[win_id];
        end
    end

    assign take_req = (state_q == ST_OFFER);

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int N_IRQ = 16,
    parameter int LVL_W = 8,
    localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_en,
    input logic             priv_s,
    input logic             mie,
    input logic             sie,
    input logic [LVL_W-1:0] m_thresh,
    input logic [LVL_W-1:0] s_thresh,
    input logic [LVL_W-1:0] m_active,
    input logic [LVL_W-1:0] s_active,
    input logic             take_ack,
    input logic             take_req,
    input logic [ID_W-1:0]  take_id,
    input logic [LVL_W-1:0] take_lvl,
    input logic             take_smode
);

    AST_OFFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> |(($past(irq_en) >> take_id) & N_IRQ'(1))); // R1

    AST_M_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !take_smode && !$past(priv_s)) |-> $past(mie)); // R2

    AST_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (take_lvl > (take_smode ? $past(s_thresh) : $past(m_thresh)))); // R3

    AST_S_NOT_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && take_smode) |-> $past(priv_s)); // R5

    AST_S_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && take_smode) |-> $past(sie)); // R6

    AST_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (take_lvl > (take_smode ? $past(s_active) : $past(m_active)))); // R9

    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && take_ack) |=> !take_req); // R12

endmodule

bind irq_arb_top irq_arb_chk #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .priv_s     (priv_s),
    .mie        (mie),
    .sie        (sie),
    .m_thresh   (m_thresh),
    .s_thresh   (s_thresh),
    .m_active   (m_active),
    .s_active   (s_active),
    .take_ack   (take_ack),
    .take_req   (take_req),
    .take_id    (take_id),
    .take_lvl   (take_lvl),
    .take_smode (take_smode)
);

// File: tb/test_irq_arb_top.sv
`timescale 1ns/1ps
module test_irq_arb_top;

    localparam int N  = 16;
    localparam int LW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_line, irq_sw_clr, irq_en, irq_smode, irq_edge, irq_vec;
    logic [N*LW-1:0] irq_lvl;
    logic          priv_s, mie, sie, take_ack;
    logic [LW-1:0] m_thresh, s_thresh, m_active, s_active;
    logic          take_req, take_smode, take_vec;
    logic [IW-1:0] take_id;
    logic [LW-1:0] take_lvl;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic  req;
        int    id;
        int    lvl;
        logic  sm;
        logic  vec;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    irq_arb_top #(.N_IRQ(N), .LVL_W(LW)) i_irq_arb_top (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_sw_clr(irq_sw_clr),
        .irq_en(irq_en), .irq_smode(irq_smode), .irq_edge(irq_edge), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl), .priv_s(priv_s), .mie(mie), .sie(sie),
        .m_thresh(m_thresh), .s_thresh(s_thresh), .m_active(m_active), .s_active(s_active),
        .take_ack(take_ack), .take_req(take_req), .take_id(take_id), .take_lvl(take_lvl),
        .take_smode(take_smode), .take_vec(take_vec)
    );

    // monitor: compares each expected item against the ports as soon as it is queued
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            n_checks++;
            if (take_req !== e.req) begin
                n_errors++;
                $display("FAIL %s: take_req=%0b expected %0b", e.tag, take_req, e.req);
            end else if (e.req && (int'(take_id) != e.id || int'(take_lvl) != e.lvl ||
                                   take_smode !== e.sm || take_vec !== e.vec)) begin
                n_errors++;
                $display("FAIL %s: id=%0d lvl=%0d sm=%0b vec=%0b expected id=%0d lvl=%0d sm=%0b vec=%0b",
                         e.tag, take_id, take_lvl, take_smode, take_vec, e.id, e.lvl, e.sm, e.vec);
            end
        end
    end

    task automatic expect_out(input logic req, input int id, input int lvl,
                              input logic sm, input logic vec, input string tag);
        exp_t e;
        e.req = req; e.id = id; e.lvl = lvl; e.sm = sm; e.vec = vec; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int i, input logic en, input logic sm, input logic ed,
                       input logic vc, input int lvl);
        irq_en[i] = en; irq_smode[i] = sm; irq_edge[i] = ed; irq_vec[i] = vc;
        irq_lvl[i*LW +: LW] = LW'(lvl);
    endtask

    task automatic clear_all();
        irq_line = '0; irq_sw_clr = '0; irq_en = '0; irq_smode = '0;
        irq_edge = '0; irq_vec = '0; irq_lvl = '0;
        priv_s = 1'b0; mie = 1'b1; sie = 1'b1; take_ack = 1'b0;
        m_thresh = '0; s_thresh = '0; m_active = '0; s_active = '0;
        step(4);
    endtask

    task automatic ack_pulse();
        take_ack = 1'b1;
        step(1);
        take_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        clear_all();
        step(2);
        expect_out(0, 0, 0, 0, 0, "R12 reset state");
        rst_n = 1'b1;
        step(2);

        // R1: disabled source ignored, then one clock to offer after enable
        clear_all();
        cfg(3, 0, 0, 0, 1, 20);
        irq_line[3] = 1'b1;
        step(4);
        expect_out(0, 0, 0, 0, 0, "R1 disabled pending source");
        irq_en[3] = 1'b1;
        step(1);
        expect_out(1, 3, 20, 0, 1, "R1/R12 offered one clock after enable");

        // R2: machine global enable in machine mode
        mie = 1'b0;
        step(3);
        expect_out(0, 0, 0, 0, 0, "R2 mie=0 in machine mode");
        mie = 1'b1;
        step(3);
        expect_out(1, 3, 20, 0, 1, "R2 mie=1 in machine mode");

        // R3: threshold strictly below
        m_thresh = 8'd20;
        step(3);
        expect_out(0, 0, 0, 0, 0, "R3 level equal to threshold");
        m_thresh = 8'd19;
        step(3);
        expect_out(1, 3, 20, 0, 1, "R3 level above threshold");

        // R4: machine source from supervisor with mie=0
        priv_s = 1'b1; mie = 1'b0; m_thresh = '0;
        step(3);
        expect_out(1, 3, 20, 0, 1, "R4 machine source from supervisor");

        // R5/R6: supervisor source
        clear_all();
        cfg(7, 1, 1, 0, 0, 60);
        irq_line[7] = 1'b1;
        step(4);
        expect_out(0, 0, 0, 0, 0, "R5 supervisor source in machine mode");
        priv_s = 1'b1; sie = 1'b0;
        step(3);
        expect_out(0, 0, 0, 0, 0, "R6 sie=0 in supervisor mode");
        sie = 1'b1;
        step(3);
        expect_out(1, 7, 60, 1, 0, "R6 sie=1 in supervisor mode");

        // R7: machine beats supervisor of higher level
        cfg(2, 1, 0, 0, 0, 10);
        irq_line[2] = 1'b1;
        step(3);
        expect_out(1, 2, 10, 0, 0, "R7 machine over supervisor");

        // R8: level order and tie on index
        clear_all();
        cfg(2, 1, 0, 0, 0, 10);
        cfg(9, 1, 0, 0, 0, 50);
        irq_line[2] = 1'b1; irq_line[9] = 1'b1;
        step(4);
        expect_out(1, 9, 50, 0, 0, "R8 higher level wins");
        cfg(12, 1, 0, 0, 0, 50);
        irq_line[12] = 1'b1;
        step(4);
        expect_out(1, 12, 50, 0, 0, "R8 tie goes to higher index");

        // R9: active level blocks preemption
        clear_all();
        cfg(1, 1, 0, 0, 0, 50);
        irq_line[1] = 1'b1;
        m_active = 8'd50;
        step(4);
        expect_out(0, 0, 0, 0, 0, "R9 level equal to active");
        m_active = 8'd49;
        step(3);
        expect_out(1, 1, 50, 0, 0, "R9 taken after active drops");

        // R12: level line latency is two clocks
        clear_all();
        cfg(5, 1, 0, 0, 0, 9);
        irq_line[5] = 1'b1;
        step(1);
        expect_out(0, 0, 0, 0, 0, "R12 no offer one clock after line");
        step(1);
        expect_out(1, 5, 9, 0, 0, "R12 offer two clocks after line");

        // R10: vectored edge source cleared by acknowledge
        clear_all();
        cfg(4, 1, 0, 1, 1, 30);
        irq_line[4] = 1'b1;
        step(1);
        irq_line[4] = 1'b0;
        step(2);
        expect_out(1, 4, 30, 0, 1, "R10 edge source offered after pulse");
        ack_pulse();
        expect_out(0, 0, 0, 0, 0, "R12 request low after acknowledge");
        step(1);
        expect_out(0, 0, 0, 0, 0, "R10 vectored edge cleared by acknowledge");
        step(2);
        expect_out(0, 0, 0, 0, 0, "R10 vectored edge stays cleared");

        // R10: non-vectored edge stays pending until software clear
        clear_all();
        cfg(4, 1, 0, 1, 0, 30);
        irq_line[4] = 1'b1;
        step(1);
        irq_line[4] = 1'b0;
        step(2);
        expect_out(1, 4, 30, 0, 0, "R10 non-vectored edge offered");
        ack_pulse();
        expect_out(0, 0, 0, 0, 0, "R12 gap after acknowledge");
        step(1);
        expect_out(1, 4, 30, 0, 0, "R10 non-vectored edge still pending");
        irq_sw_clr[4] = 1'b1;
        step(1);
        irq_sw_clr[4] = 1'b0;
        step(2);
        expect_out(0, 0, 0, 0, 0, "R10 software clear removes edge pending");

        // R11: level source re-offered after acknowledge
        clear_all();
        cfg(2, 1, 0, 0, 1, 40);
        irq_line[2] = 1'b1;
        step(3);
        expect_out(1, 2, 40, 0, 1, "R11 level source offered");
        ack_pulse();
        expect_out(0, 0, 0, 0, 0, "R12 gap after level acknowledge");
        step(1);
        expect_out(1, 2, 40, 0, 1, "R11 level source offered again");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule